// File: doc/BRIEF.md
# Programmable I2C Clock-Phase Sequencer

This block produces the SCL waveform of an I2C master, one bit cycle at a time, together with the strobes that tell the data path when to sample SDA and when to change it. Every bit consists of a released (high) phase followed by a driven-low phase. The length of each phase is a programmed count plus a fixed edge pad. One programmed offset inside the high phase raises a one-cycle sample strobe. A second offset inside the low phase raises a one-cycle launch strobe. A bit-done pulse marks the last low cycle. If another bit is requested on that cycle, the next high phase follows with no gap.

Six counts come in as plain input ports: high, sample point, low, launch point, lead-in and bus-free. Firmware normally derives them from a base value, base = ((f_clk / rate) − 38) / 2. From that base, high = base + 3, low = base − 3, the sample point is three quarters of the high count and the launch point is a quarter of the low count. With an edge pad of 19 cycles per phase, one bit takes exactly 2·(high − 3) + 38 reference cycles.

When the block is enabled it first waits out the lead-in interval. It then needs the SCL line to stay high and idle for the bus-free interval before it will start a bit. A slave that holds SCL low while the master releases it freezes the high-phase timing; this is clock stretching.

Top module: `sclg_timing`

## Requirements
- R1: While `en` has been sampled low, `scl_out` is 1, and `bus_free`, `sample_stb`, `launch_stb` and `bit_done` are all 0. This is also the state right after reset.
- R2: Suppose `en` is first seen high in cycle c and `scl_in` stays high. Then `bus_free` first rises in cycle c + lead_cnt + free_cnt + 1 (lead_cnt ≥ 1).
- R3: `bit_req` is ignored while `bus_free` is 0. No SCL low phase and no strobe occurs outside an accepted bit.
- R4: A bit is accepted in a cycle where `bus_free` and `bit_req` are both 1. Its high phase starts in the next cycle and lasts hi_cnt + 19 cycles, after which `scl_out` falls to 0.
- R5: The low phase lasts lo_cnt + 19 cycles. `bit_done` is 1 only in its last cycle.
- R6: `sample_stb` pulses exactly once per bit, rx_cnt cycles after the high phase starts.
- R7: `launch_stb` pulses exactly once per bit, tx_cnt cycles after `scl_out` falls. A tx_cnt of 0 places it in the falling cycle.
- R8: If `bit_req` is 1 in the `bit_done` cycle, the next high phase starts in the following cycle. With counts derived from base, the start-to-start bit period is 2·base + 38 cycles.
- R9: In a high-phase cycle where `scl_in` is 0, the phase count does not advance. Each such cycle delays the sample strobe, if it is still pending, and the fall by one cycle.
- R10: After the last bit, `bus_free` rises free_cnt + 1 cycles after the `bit_done` cycle. It is only ever 1 while the line is high and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; low forces the idle-off state |
| bit_req | input | 1 | Request for one bit cycle |
| scl_in | input | 1 | Sampled SCL line level |
| hi_cnt | input | CW | High-phase count |
| rx_cnt | input | CW | Sample offset from start of high phase |
| lo_cnt | input | CW | Low-phase count |
| tx_cnt | input | CW | Launch offset from start of low phase |
| free_cnt | input | CW | Bus-free interval in cycles |
| lead_cnt | input | CW | Lead-in interval after enable |
| scl_out | output | 1 | SCL drive: 1 releases, 0 pulls low |
| sample_stb | output | 1 | One-cycle SDA sample strobe |
| launch_stb | output | 1 | One-cycle SDA launch strobe |
| bit_done | output | 1 | Last cycle of the low phase |
| bus_free | output | 1 | Bus-free interval has elapsed with the line idle |

## Verification
The bench builds the block with its defaults: 16-bit counts, an edge pad of 19 cycles and stretching enabled. The pad makes the start-to-start bit period match the firmware rate formula, so periods can be checked directly against 2·base + 38. The 16-bit counts reach the slow end of the rate range, where base is near 981, as well as the fast end at 540 kHz, where the low count is zero and the launch strobe falls in the same cycle as SCL. With stretching enabled, random low pulses on the sensed line move both the sample strobe and the fall.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

   typedef enum logic [2:0] {
      PH_OFF  = 3'd0,
      PH_LEAD = 3'd1,
      PH_IDLE = 3'd2,
      PH_HIGH = 3'd3,
      PH_LOW  = 3'd4
   } phase_t;

endpackage

// File: rtl/sclg_counter.sv
module sclg_counter #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (inc)
         q <= q + ONE;
   end
endmodule

// File: rtl/sclg_idle_timer.sv
module sclg_idle_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         reached
);
   localparam logic [W-1:0] ONE = W'(1);
   logic [W-1:0] q;

   // saturating: stops at the limit so a long idle never wraps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (!run)
         q <= '0;
      else if (q < limit)
         q <= q + ONE;
   end

   assign reached = (q >= limit);
endmodule

// File: rtl/sclg_phase_fsm.sv
module sclg_phase_fsm
   import sclg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  logic   bit_req,
   input  logic   bus_ok,
   input  logic   term,
   output phase_t ph,
   output phase_t ph_nxt
);
   always_comb begin
      ph_nxt = ph;
      if (!en) begin
         ph_nxt = PH_OFF;
      end else begin
         unique case (ph)
            PH_OFF:  ph_nxt = PH_LEAD;
            PH_LEAD: if (term) ph_nxt = PH_IDLE;
            PH_IDLE: if (bit_req && bus_ok) ph_nxt = PH_HIGH;
            PH_HIGH: if (term) ph_nxt = PH_LOW;
            PH_LOW:  if (term) ph_nxt = bit_req ? PH_HIGH : PH_IDLE;
            default: ph_nxt = PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= PH_OFF;
      else
         ph <= ph_nxt;
   end
endmodule

// File: rtl/sclg_timing.sv
module sclg_timing
   import sclg_pkg::*;
#(
   parameter int CW       = 16,
   parameter int EDGE_PAD = 19,
   parameter int STRETCH  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          bit_req,
   input  logic          scl_in,
   input  logic [CW-1:0] hi_cnt,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] lo_cnt,
   input  logic [CW-1:0] tx_cnt,
   input  logic [CW-1:0] free_cnt,
   input  logic [CW-1:0] lead_cnt,
   output logic          scl_out,
   output logic          sample_stb,
   output logic          launch_stb,
   output logic          bit_done,
   output logic          bus_free
);
   // one spare bit so count + pad never wraps
   localparam int PW = CW + 1;
   localparam logic [PW-1:0] PAD_V = PW'(EDGE_PAD);

   generate
      if (CW < 2) begin : g_bad_cw
         $error("sclg_timing: CW must be at least 2");
      end
      if (EDGE_PAD < 0 || EDGE_PAD >= (1 << CW)) begin : g_bad_pad
         $error("sclg_timing: EDGE_PAD out of range for CW");
      end
      if (STRETCH != 0 && STRETCH != 1) begin : g_bad_str
         $error("sclg_timing: STRETCH must be 0 or 1");
      end
   endgenerate

   phase_t        ph, ph_nxt;
   logic [PW-1:0] cnt;
   logic [PW-1:0] ph_len;
   logic [PW:0]   cnt_inc;
   logic          line_hi;
   logic          adv;
   logic          timed;
   logic          term;
   logic          cnt_clr;
   logic          idle_run;
   logic          idle_reached;
   logic          bus_ok;

   // variant: whether a held-low line freezes the high phase
   generate
      if (STRETCH != 0) begin : g_stretch
         assign line_hi = scl_in;
      end else begin : g_no_stretch
         assign line_hi = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (ph)
         PH_LEAD: ph_len = {1'b0, lead_cnt};
         PH_HIGH: ph_len = {1'b0, hi_cnt} + PAD_V;
         PH_LOW:  ph_len = {1'b0, lo_cnt} + PAD_V;
         default: ph_len = '0;
      endcase
   end

   assign timed   = (ph == PH_LEAD) || (ph == PH_HIGH) || (ph == PH_LOW);
   assign adv     = (ph == PH_HIGH) ? line_hi : 1'b1;
   assign cnt_inc = {1'b0, cnt} + {{PW{1'b0}}, 1'b1};
   assign term    = timed && adv && (cnt_inc >= {1'b0, ph_len});
   assign cnt_clr = (ph_nxt != ph) || !timed;

   assign idle_run = (ph == PH_IDLE) && scl_in;
   assign bus_ok   = idle_run && idle_reached;

   sclg_phase_fsm i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .bit_req (bit_req),
      .bus_ok  (bus_ok),
      .term    (term),
      .ph      (ph),
      .ph_nxt  (ph_nxt)
   );

   sclg_counter #(.W(PW)) i_phase_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (adv),
      .q     (cnt)
   );

   sclg_idle_timer #(.W(CW)) i_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (idle_run),
      .limit   (free_cnt),
      .reached (idle_reached)
   );

   assign scl_out    = (ph != PH_LOW);
   assign sample_stb = (ph == PH_HIGH) && adv && (cnt == {1'b0, rx_cnt});
   assign launch_stb = (ph == PH_LOW) && (cnt == {1'b0, tx_cnt});
   assign bit_done   = (ph == PH_LOW) && term;
   assign bus_free   = bus_ok;

endmodule

// File: rtl/sclg_checker.sv
module sclg_checker #(
   parameter int STRETCH = 1
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic scl_in,
   input logic scl_out,
   input logic sample_stb,
   input logic launch_stb,
   input logic bit_done,
   input logic bus_free
);
   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (scl_out && !bus_free && !sample_stb && !launch_stb && !bit_done));

   p_no_free_when_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !scl_out |-> !bus_free);

   p_done_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |-> !scl_out);

   p_sample_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   p_launch_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      launch_stb |-> !scl_out);

   p_release_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |=> scl_out);

   p_sample_on_high_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (scl_in && scl_out));

   p_fall_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_out) && (STRETCH != 0)) |-> $past(scl_in));

   p_free_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_free |-> (scl_in && scl_out));
endmodule

bind sclg_timing sclg_checker #(.STRETCH(STRETCH)) i_sclg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .scl_in     (scl_in),
   .scl_out    (scl_out),
   .sample_stb (sample_stb),
   .launch_stb (launch_stb),
   .bit_done   (bit_done),
   .bus_free   (bus_free)
);

// File: tb/test_sclg_timing.sv
`timescale 1ns/1ps
module test_sclg_timing;
   localparam int CW   = 16;
   localparam int PAD  = 19;
   localparam int FCLK = 24000000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic bit_req = 1'b0;
   logic ext_low = 1'b0;
   logic scl_in;
   logic [CW-1:0] hi_cnt = '0, rx_cnt = '0, lo_cnt = '0, tx_cnt = '0;
   logic [CW-1:0] free_cnt = '0, lead_cnt = 16'd1;
   logic scl_out, sample_stb, launch_stb, bit_done, bus_free;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int wd = 0;
   int cfg_base = 0;
   int en_cyc = 0, hi_start = 0, lo_start = 0, done_cyc = 0;
   int stall = 0, nsamp = 0, nlaunch = 0, nacc = 0, ndone = 0, early_viol = 0;
   bit in_hi = 0, in_lo = 0, exp_bf_en = 0, exp_bf_bit = 0;
   bit en_p = 0, bf_p = 0, scl_p = 1;

   assign scl_in = scl_out & ~ext_low;

   always #5 clk = ~clk;

   sclg_timing #(.CW(CW), .EDGE_PAD(PAD), .STRETCH(1)) i_sclg_timing (
      .clk(clk), .rst_n(rst_n), .en(en), .bit_req(bit_req), .scl_in(scl_in),
      .hi_cnt(hi_cnt), .rx_cnt(rx_cnt), .lo_cnt(lo_cnt), .tx_cnt(tx_cnt),
      .free_cnt(free_cnt), .lead_cnt(lead_cnt),
      .scl_out(scl_out), .sample_stb(sample_stb), .launch_stb(launch_stb),
      .bit_done(bit_done), .bus_free(bus_free)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // monitor: samples at the falling edge, inputs change 2 ns after rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (!en && !en_p)
            chk(scl_out && !sample_stb && !launch_stb && !bit_done && !bus_free,
                "R1 outputs while disabled",
                {scl_out, sample_stb, launch_stb, bit_done, bus_free}, 5'b10000);
         if (!en) begin
            in_hi = 0; in_lo = 0; exp_bf_en = 0; exp_bf_bit = 0;
         end
         if (en && !en_p) begin
            en_cyc = cyc; exp_bf_en = 1;
         end
         if (!in_hi && !in_lo && (!scl_out || sample_stb || launch_stb || bit_done))
            early_viol++;
         if (bus_free && !bf_p) begin
            if (exp_bf_en) begin
               chk(cyc == en_cyc + int'(lead_cnt) + int'(free_cnt) + 1, "R2 bus free after enable",
                   cyc - en_cyc, int'(lead_cnt) + int'(free_cnt) + 1);
               exp_bf_en = 0;
            end else if (exp_bf_bit) begin
               chk(cyc == done_cyc + int'(free_cnt) + 1, "R10 bus free after last bit",
                   cyc - done_cyc, int'(free_cnt) + 1);
               exp_bf_bit = 0;
            end
         end
         if (sample_stb && in_hi) begin
            chk(cyc == hi_start + int'(rx_cnt) + stall, "R6 R9 sample position",
                cyc - hi_start, int'(rx_cnt) + stall);
            nsamp++;
         end
         if (!scl_out && scl_p && in_hi) begin
            chk(cyc == hi_start + int'(hi_cnt) + PAD + stall, "R4 R9 high phase length",
                cyc - hi_start, int'(hi_cnt) + PAD + stall);
            chk(nsamp == 1, "R6 one sample per bit", nsamp, 1);
            in_hi = 0; in_lo = 1; lo_start = cyc; nlaunch = 0;
         end
         if (launch_stb && in_lo) begin
            chk(cyc == lo_start + int'(tx_cnt), "R7 launch position",
                cyc - lo_start, int'(tx_cnt));
            nlaunch++;
         end
         if (bit_done && in_lo) begin
            chk(cyc == lo_start + int'(lo_cnt) + PAD - 1, "R5 low phase length",
                cyc - lo_start + 1, int'(lo_cnt) + PAD);
            chk(nlaunch == 1, "R7 one launch per bit", nlaunch, 1);
            in_lo = 0; done_cyc = cyc; ndone++;
            if (bit_req) begin
               if (stall == 0)
                  chk(cyc + 1 - hi_start == 2 * cfg_base + 38, "R8 chained bit period",
                      cyc + 1 - hi_start, 2 * cfg_base + 38);
               hi_start = cyc + 1; in_hi = 1; stall = 0; nsamp = 0; nacc++;
            end else begin
               exp_bf_bit = 1;
            end
         end else if (bus_free && bit_req && !in_hi && !in_lo) begin
            hi_start = cyc + 1; in_hi = 1; stall = 0; nsamp = 0; nacc++;
         end
         if (in_hi && cyc >= hi_start && scl_out && !scl_in)
            stall++;
         en_p = en; bf_p = bus_free; scl_p = scl_out;
      end
   end

   function automatic bit rate_ok(input int speed);
      return (speed >= 12000) && (speed <= 540000);
   endfunction

   function automatic int base_of(input int speed);
      return ((FCLK / speed) - 38) / 2;
   endfunction

   task automatic step_ext(input bit stretch);
      @(posedge clk); #2;
      ext_low = stretch && in_hi && ($urandom_range(0, 2) == 0);
   endtask

   task automatic run_xfer(input int speed, input int nbits, input bit stretch,
                           input bit early, input int lead, input int free);
      int b;
      if (!rate_ok(speed)) begin
         $display("rate %0d Hz rejected: outside 12 kHz..540 kHz", speed);
         return;
      end
      b = base_of(speed);
      @(posedge clk); #2;
      en = 0; bit_req = 0; ext_low = 0;
      repeat (3) @(posedge clk);
      #2;
      cfg_base = b;
      hi_cnt   = CW'(b + 3);
      lo_cnt   = CW'(b - 3);
      rx_cnt   = CW'(((b + 3) * 3) / 4);
      tx_cnt   = CW'((b - 3) / 4);
      lead_cnt = CW'(lead);
      free_cnt = CW'(free);
      nacc = 0; ndone = 0; early_viol = 0;
      @(posedge clk); #2;
      en = 1;
      if (early) bit_req = 1;
      else begin
         wait (bus_free);
         @(posedge clk); #2;
         bit_req = 1;
      end
      while (nacc < nbits) step_ext(stretch);
      bit_req = 0;
      while (!(ndone == nbits && !exp_bf_bit)) step_ext(stretch);
      ext_low = 0;
      chk(early_viol == 0, "R3 no SCL activity outside accepted bits", early_viol, 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      chk(scl_out && !sample_stb && !launch_stb && !bit_done && !bus_free, "R1 reset state",
          {scl_out, sample_stb, launch_stb, bit_done, bus_free}, 5'b10000);
      // directed corners
      run_xfer(400000, 3, 0, 0, 48, 48);
      run_xfer(540000, 2, 0, 1, 1, 0);
      run_xfer(12000, 1, 1, 0, 5, 7);
      run_xfer(600000, 1, 0, 0, 4, 4);
      run_xfer(11000, 1, 0, 0, 4, 4);
      run_xfer(100000, 4, 1, 1, 20, 3);
      // random mix
      for (int k = 0; k < 10; k++)
         run_xfer($urandom_range(50000, 540000), $urandom_range(1, 4),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  $urandom_range(1, 64), $urandom_range(0, 64));
      @(posedge clk); #2 en = 0;
      repeat (4) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      wd++;
      if (wd == 190000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule